// File: doc/BRIEF.md
# Byte-lane asynchronous memory port with dual chip select

This block is the device side of a 16-bit asynchronous static-style memory, built as clocked logic around a small word array. Six control pins arrive without a clock: an active-low select, an active-high select, an active-low write strobe, an active-low output enable and one active-low enable per byte lane. A fast sampling clock synchronizes them, together with the address and the incoming data. From the synchronized pins the block works out whether the chip is in standby, reading, writing or selected with its outputs off.

For each byte lane the block drives its own output-enable signal for an external tri-state data bus. Reads turn a lane on only after the request and the address have been steady for a set number of sampling cycles. This stands in for the access time. A write stays open while the strobe, both selects and at least one lane enable are all active. It commits to the array on the clock edge where that window is seen to close. The lanes that are stored, the address and the data are the ones held in the last sampled cycle of the window. A standby flag reports the deselected power state.

The address is 18 bits wide at the pins, but only its low log2(DEPTH) bits select a word in the reduced-depth array.

Top module: `byte_lane_sram_port`

## Requirements
- R1: `standby` is 1 exactly when the synchronized pins show `sel_a_n`=1, or `sel_b`=0, or `lane_en_n`=2'b11. The flag follows a pin change SYNC_STAGES clock edges later.
- R2: While `standby` is 1, `lane_drive` is 2'b00.
- R3: In read mode (selected, `wr_en_n`=1, `out_en_n`=0), bit 0 of `lane_en_n` low drives the stored low byte on `rdata_out[7:0]` and sets `lane_drive[0]`. Bit 1 low does the same with the high byte on `rdata_out[15:8]` and `lane_drive[1]`. A lane that is not driven shows 8'h00.
- R4: A lane's drive rises SYNC_STAGES+ACC_CYCLES edges after a read request with a steady address appears at the pins. It falls SYNC_STAGES edges after the request is withdrawn. An address change restarts the count.
- R5: When selected with `wr_en_n`=1 and `out_en_n`=1, no lane is driven and `standby` stays 0.
- R6: When selected with `wr_en_n`=0, the port writes whatever the level of `out_en_n`. No lane is driven and `standby` stays 0.
- R7: A write updates only the bytes whose lane enable bit is 0. The other byte keeps its old value.
- R8: The stored data is the value present in the last cycle of the write window. The window may be closed by the write strobe, either select or the lane enables.
- R9: Address bits at and above log2(DEPTH) do not affect which word is accessed.
- R10: After reset, `standby` is 1 and `lane_drive` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| wr_en_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| lane_en_n | input | 2 | Active-low byte-lane enables, bit 0 low byte |
| addr | input | 18 | Word address |
| wdata_in | input | 16 | Data from the bus during writes |
| rdata_out | output | 16 | Read data toward the bus |
| lane_drive | output | 2 | Per-lane bus output enable |
| standby | output | 1 | Deselected power state flag |

## Verification
Every pin passes through SYNC_STAGES flops, so `standby` and the falling edge of a lane drive appear SYNC_STAGES edges after the stimulus. A rising drive with its read data needs ACC_CYCLES more edges. A write lands in the array on the edge where the synchronized window is seen closed, which is SYNC_STAGES edges after the closing pin change. The bench drives and samples one time unit after a rising edge. It checks the latency cases one edge early and exactly on time. For every other vector it waits SYNC_STAGES+ACC_CYCLES+1 edges before sampling, and it holds the idle state SYNC_STAGES+1 edges before reading back a written word.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic                 sel_a_n;
        logic                 sel_b;
        logic                 wr_n;
        logic                 oe_n;
        logic [NUM_LANES-1:0] lane_n;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{sel_a_n: 1'b1, sel_b: 1'b0, wr_n: 1'b1,
                                    oe_n: 1'b1, lane_n: '1};

    typedef enum logic [1:0] {
        MD_STANDBY = 2'd0,
        MD_READ    = 2'd1,
        MD_WRITE   = 2'd2,
        MD_NOOUT   = 2'd3
    } mode_t;

    function automatic mode_t chip_mode(input pins_t p);
        if (p.sel_a_n || !p.sel_b || (&p.lane_n)) return MD_STANDBY;
        else if (!p.wr_n)                         return MD_WRITE;
        else if (!p.oe_n)                         return MD_READ;
        else                                      return MD_NOOUT;
    endfunction

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/psr_decode.sv
module psr_decode
    import psr_pkg::*;
(
    input  pins_t                pins,
    output logic                 standby,
    output logic                 wr_act,
    output logic [NUM_LANES-1:0] rd_req,
    output logic [NUM_LANES-1:0] wr_lanes
);
    mode_t mode;

    always_comb begin
        mode     = chip_mode(pins);
        standby  = (mode == MD_STANDBY);
        wr_act   = (mode == MD_WRITE);
        rd_req   = (mode == MD_READ)  ? ~pins.lane_n : '0;
        wr_lanes = (mode == MD_WRITE) ? ~pins.lane_n : '0;
    end
endmodule

// File: rtl/psr_lane_timer.sv
module psr_lane_timer #(
    parameter int ACC_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic addr_chg,
    output logic lane_on
);
    localparam int CNT_W = $clog2(ACC_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ACC_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !req)        cnt <= '0;
        else if (addr_chg)      cnt <= CNT_W'(1);
        else if (cnt < CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign lane_on = req && !addr_chg && (cnt >= CNT_MAX);
endmodule

// File: rtl/psr_array.sv
module psr_array
    import psr_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int DATA_W = NUM_LANES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_act,
    input  logic [NUM_LANES-1:0] wr_lanes,
    input  logic [IDX_W-1:0]     idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0]    mem [DEPTH];
    logic                 win_q;
    logic [IDX_W-1:0]     widx_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [NUM_LANES-1:0] wlanes_q;
    logic                 commit;

    // capture the most recent cycle of the open window
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= 1'b0;
            widx_q   <= '0;
            wdata_q  <= '0;
            wlanes_q <= '0;
        end else begin
            win_q <= wr_act;
            if (wr_act) begin
                widx_q   <= idx;
                wdata_q  <= wdata;
                wlanes_q <= wr_lanes;
            end
        end
    end

    assign commit = win_q && !wr_act;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (wlanes_q[l]) mem[widx_q][l*BYTE_W +: BYTE_W] <= wdata_q[l*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rdata = mem[idx];

    AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
        commit |-> (wlanes_q != '0));  // R7
endmodule

// File: rtl/byte_lane_sram_port.sv
module byte_lane_sram_port
    import psr_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2,
    parameter int ACC_CYCLES  = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            sel_a_n,
    input  logic                            sel_b,
    input  logic                            wr_en_n,
    input  logic                            out_en_n,
    input  logic [NUM_LANES-1:0]            lane_en_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_LANES*BYTE_W-1:0]     wdata_in,
    output logic [NUM_LANES*BYTE_W-1:0]     rdata_out,
    output logic [NUM_LANES-1:0]            lane_drive,
    output logic                            standby
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int DATA_W = NUM_LANES * BYTE_W;
    localparam int BUS_W  = PIN_W + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] BUS_RST = {PINS_IDLE, {(ADDR_W + DATA_W){1'b0}}};

    pins_t                pins_raw, s_pins;
    logic [ADDR_W-1:0]    s_addr, addr_q;
    logic [DATA_W-1:0]    s_data, arr_rdata;
    logic [BUS_W-1:0]     bus_raw, bus_s;
    logic                 wr_act, addr_chg;
    logic [NUM_LANES-1:0] rd_req, wr_lanes;

    assign pins_raw = '{sel_a_n: sel_a_n, sel_b: sel_b, wr_n: wr_en_n,
                        oe_n: out_en_n, lane_n: lane_en_n};
    assign bus_raw  = {pins_raw, addr, wdata_in};

    psr_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_s)
    );

    assign {s_pins, s_addr, s_data} = bus_s;

    psr_decode u_dec (
        .pins     (s_pins),
        .standby  (standby),
        .wr_act   (wr_act),
        .rd_req   (rd_req),
        .wr_lanes (wr_lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= s_addr;
    end
    assign addr_chg = (s_addr != addr_q);

    psr_array #(.DEPTH(DEPTH)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .wr_act   (wr_act),
        .wr_lanes (wr_lanes),
        .idx      (s_addr[IDX_W-1:0]),
        .wdata    (s_data),
        .rdata    (arr_rdata)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        psr_lane_timer #(.ACC_CYCLES(ACC_CYCLES)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .req      (rd_req[g]),
            .addr_chg (addr_chg),
            .lane_on  (lane_drive[g])
        );
        assign rdata_out[g*BYTE_W +: BYTE_W] = lane_drive[g] ? arr_rdata[g*BYTE_W +: BYTE_W] : '0;

        AST_LANE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            lane_drive[g] |-> !s_pins.lane_n[g]);  // R3
        AST_DRIVE_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
            (lane_drive[g] && $past(lane_drive[g])) |-> $stable(s_addr));  // R4
    end

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        standby |-> (lane_drive == '0));  // R2
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!standby && !s_pins.wr_n) |-> (lane_drive == '0));  // R6
    AST_NOOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!standby && s_pins.oe_n) |-> (lane_drive == '0));  // R5
endmodule

// File: tb/byte_lane_sram_port_test.sv
module byte_lane_sram_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 18;
    localparam int DEPTH  = 256;
    localparam int SYNC   = 2;
    localparam int ACC    = 3;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, wr_en_n = 1'b1, out_en_n = 1'b1;
    logic [1:0]  lane_en_n = 2'b11;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] wdata_in = '0;
    logic [15:0] rdata_out;
    logic [1:0]  lane_drive;
    logic        standby;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [15:0] shadow [DEPTH];

    byte_lane_sram_port #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC),
                          .ACC_CYCLES(ACC)) uut (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .lane_en_n(lane_en_n), .addr(addr), .wdata_in(wdata_in),
        .rdata_out(rdata_out), .lane_drive(lane_drive), .standby(standby));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit f_standby(logic a_n, logic b, logic [1:0] ln);
        return a_n || !b || (ln == 2'b11);
    endfunction

    function automatic logic [1:0] f_drive(logic a_n, logic b, logic w_n, logic o_n, logic [1:0] ln);
        if (f_standby(a_n, b, ln) || !w_n || o_n) return 2'b00;
        return ~ln;
    endfunction

    function automatic logic [15:0] f_data(logic [1:0] drv, logic [15:0] word);
        return {drv[1] ? word[15:8] : 8'h00, drv[0] ? word[7:0] : 8'h00};
    endfunction

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_pins(logic a_n, logic b, logic w_n, logic o_n, logic [1:0] ln,
                            logic [ADDR_W-1:0] a, logic [15:0] d);
        sel_a_n = a_n; sel_b = b; wr_en_n = w_n; out_en_n = o_n; lane_en_n = ln;
        addr = a; wdata_in = d;
    endtask

    task automatic go_idle();
        sel_a_n = 1'b1;
        edges(SYNC + 1);
        chk("R2 idle drive", 32'(lane_drive), 32'h0);
    endtask

    // apply one vector, check steady outputs, then deselect and track writes
    task automatic apply(logic a_n, logic b, logic w_n, logic o_n, logic [1:0] ln,
                         logic [ADDR_W-1:0] a, logic [15:0] d);
        logic [1:0] drv;
        logic [IDX_W-1:0] ix;
        ix = a[IDX_W-1:0];
        set_pins(a_n, b, w_n, o_n, ln, a, d);
        edges(SYNC + ACC + 1);
        drv = f_drive(a_n, b, w_n, o_n, ln);
        chk("R1 standby", 32'(standby), 32'(f_standby(a_n, b, ln)));
        chk("R3/R5/R6 lane drive", 32'(lane_drive), 32'(drv));
        chk("R3 read data", 32'(rdata_out), 32'(f_data(drv, shadow[ix])));
        go_idle();
        if (!f_standby(a_n, b, ln) && !w_n) begin
            if (!ln[0]) shadow[ix][7:0]  = d[7:0];
            if (!ln[1]) shadow[ix][15:8] = d[15:8];
        end
    endtask

    task automatic read_word(string req, logic [ADDR_W-1:0] a, logic [15:0] exp);
        set_pins(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, a, 16'h0);
        edges(SYNC + ACC + 1);
        chk(req, 32'(rdata_out), 32'(exp));
        go_idle();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        edges(3);
        rst = 1'b0;
        #1;
        chk("R10 reset standby", 32'(standby), 32'h1);
        chk("R10 reset drive", 32'(lane_drive), 32'h0);

        // fill every word so reads have known contents
        for (int i = 0; i < DEPTH; i++)
            apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, ADDR_W'(i), 16'($urandom));

        // walk all control combinations
        for (int c = 0; c < 64; c++)
            apply(c[5], c[4], c[3], c[2], c[1:0], ADDR_W'($urandom), 16'($urandom));

        // R4: rise timing, address restart, and fall timing
        set_pins(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, ADDR_W'(5), 16'h0);
        edges(SYNC + ACC - 1);
        chk("R4 drive early", 32'(lane_drive), 32'h0);
        edges(1);
        chk("R4 drive on time", 32'(lane_drive), 32'h3);
        chk("R4 data", 32'(rdata_out), 32'(shadow[5]));
        addr = ADDR_W'(6);
        edges(SYNC);
        chk("R4 addr restart", 32'(lane_drive), 32'h0);
        edges(ACC - 1);
        chk("R4 restart early", 32'(lane_drive), 32'h0);
        edges(1);
        chk("R4 restart on time", 32'(lane_drive), 32'h3);
        chk("R4 restart data", 32'(rdata_out), 32'(shadow[6]));
        out_en_n = 1'b1;
        edges(SYNC - 1);
        chk("R4 fall not yet", 32'(lane_drive), 32'h3);
        edges(1);
        chk("R4 fall R5 off", 32'(lane_drive), 32'h0);
        chk("R5 standby low", 32'(standby), 32'h0);
        go_idle();

        // R8: last data of window, closed by sel_b
        set_pins(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, ADDR_W'(9), 16'h1111);
        edges(4);
        wdata_in = 16'h2222;
        edges(4);
        sel_b = 1'b0;
        edges(SYNC + 1);
        read_word("R8 close by select", ADDR_W'(9), 16'h2222);
        // closed by lane enables
        set_pins(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, ADDR_W'(10), 16'hABCD);
        edges(4);
        lane_en_n = 2'b11;
        edges(SYNC + 1);
        read_word("R8 close by lanes", ADDR_W'(10), 16'hABCD);
        // closed by strobe, stays selected with outputs enabled
        set_pins(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, ADDR_W'(11), 16'h3C3C);
        edges(4);
        wr_en_n = 1'b1;
        edges(SYNC + ACC + 1);
        chk("R8 close by strobe", 32'(rdata_out), 32'h3C3C);
        go_idle();

        // R7: single-lane write keeps the other byte
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, ADDR_W'(12), 16'h5A5A);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, ADDR_W'(12), 16'hC3C3);
        read_word("R7 upper only", ADDR_W'(12), 16'hC35A);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b10, ADDR_W'(12), 16'h9696);
        read_word("R7 lower only", ADDR_W'(12), 16'hC396);

        // R9: upper address bits alias
        apply(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, ADDR_W'((5 << IDX_W) | 20), 16'h7E7E);
        read_word("R9 alias", ADDR_W'(20), 16'h7E7E);
        read_word("R9 alias other high", ADDR_W'((3 << IDX_W) | 20), 16'h7E7E);

        // constrained random mix, biased toward selected
        for (int i = 0; i < 200; i++) begin
            logic [1:0] ln;
            ln = 2'($urandom);
            apply(($urandom % 5) == 0, ($urandom % 5) != 0, 1'($urandom), 1'($urandom),
                  ln, ADDR_W'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule